// File: doc/BRIEF.md
# Validation Register Access Gate with Apparent Cache/TCM Size Mask

This block sits between the coprocessor register-access path and a small group of validation control registers. Each access request carries its direction (read or write), its security world (secure or non-secure) and its privilege level (privileged or user). The block combines these with a low-privilege access enable bit and a secure write lock pin. From them it decides whether the access completes or raises an undefined-instruction exception. The response is registered and returned one cycle after the request.

Two registers are reachable. The first is the apparent-size mask register. It holds four 3-bit size codes: one each for the data TCM, the instruction TCM, the data cache and the instruction cache. These codes drive the size that downstream logic reports for those memories. The second is a write-only operations register. Reads from it return zero. Writes to it have no effect on the size state. A size update happens only when the write also sets a write-enable bit, and that bit always reads back as zero. A write that carries a reserved code in any field is dropped as a whole.

Top module: `valreg_access`

## Requirements
- R1: While reset is asserted, resp_valid, undef_exc and resp_rdata are zero. The size outputs hold the implemented sizes given by parameter RST_SIZES (default dtcm=101, itcm=100, dcache=110, icache=111).
- R2: When lowpriv_allow is 0, any request from the non-secure world or from user mode (acc_secure=0 or acc_priv=0), read or write, sets undef_exc in the response.
- R3: When lowpriv_allow is 1, secure privileged, non-secure privileged and user requests complete without an exception, except for the case in R4.
- R4: A secure privileged write while sec_wr_lock is 1 sets undef_exc. A secure privileged read under the same lock completes normally.
- R5: A permitted write to the size register (acc_sel=0) with bit 31 set and all codes legal loads the size outputs on the next cycle. The field positions are dtcm [14:12], itcm [10:8], dcache [6:4] and icache [2:0].
- R6: A size-register write with bit 31 clear leaves every size output unchanged.
- R7: A permitted read of the size register returns the four codes at the R5 positions. Bit 31 and the should-be-zero bits [30:15], [11], [7] and [3] read as zero.
- R8: The legal TCM codes are 000 and 011 through 111. The legal cache codes are 011 through 111. A write with a reserved code in any field changes no size output.
- R9: A faulting request changes no size output, and its resp_rdata is zero.
- R10: A read of the operations register (acc_sel=1) returns zero. A write to it leaves the size outputs unchanged.
- R11: resp_valid is 1 exactly in the cycle after a cycle with acc_valid=1. undef_exc and resp_rdata are zero when resp_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Access request present this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_secure | input | 1 | 1 = secure world |
| acc_priv | input | 1 | 1 = privileged mode |
| acc_sel | input | 1 | 0 = size mask register, 1 = operations register |
| acc_wdata | input | 32 | Write data |
| lowpriv_allow | input | 1 | Permits non-secure and user accesses when 1 |
| sec_wr_lock | input | 1 | Blocks secure privileged writes when 1 |
| resp_valid | output | 1 | Response for the previous cycle's request |
| undef_exc | output | 1 | Request raised an undefined exception |
| resp_rdata | output | 32 | Read data of the response |
| dtcm_size | output | 3 | Apparent data TCM size code |
| itcm_size | output | 3 | Apparent instruction TCM size code |
| dcache_size | output | 3 | Apparent data cache size code |
| icache_size | output | 3 | Apparent instruction cache size code |

## Verification
A wrong size state appears directly on the four size outputs in the cycle after the write that caused it. It shows up again in the read data of the next permitted read. Because of this, a bad load enable (a lost write-enable gate, a missed reserved code, or a write let through on a fault) is visible one cycle after the request. A wrong permission decision shows up as an incorrect undef_exc on the next cycle. A leaked read value under a fault also shows up on the next cycle, as nonzero resp_rdata. The random mix keeps the privilege, world, lock and code combinations changing from one request to the next, so no stale state stays hidden for long.

// File: rtl/valreg_pkg.sv
package valreg_pkg;
  localparam int unsigned DATA_W       = 32;
  localparam int unsigned CODE_W       = 3;
  localparam int unsigned N_FIELDS     = 4;
  localparam int unsigned FIELD_STRIDE = 4;
  localparam int unsigned N_CACHE      = 2;  // fields 0..N_CACHE-1 are caches, the rest TCMs
  localparam int unsigned WEN_BIT      = 31;

  typedef enum logic {SEL_SIZE = 1'b0, SEL_OPS = 1'b1} reg_sel_e;

  typedef logic [N_FIELDS-1:0][CODE_W-1:0] size_vec_t;

  function automatic logic tcm_code_ok(input logic [CODE_W-1:0] c);
    return (c == '0) || (c >= CODE_W'(3));
  endfunction

  function automatic logic cache_code_ok(input logic [CODE_W-1:0] c);
    return c >= CODE_W'(3);
  endfunction

  function automatic logic [DATA_W-1:0] used_bits();
    logic [DATA_W-1:0] m;
    m = '0;
    m[WEN_BIT] = 1'b1;
    for (int i = 0; i < int'(N_FIELDS); i++)
      m[i*FIELD_STRIDE +: CODE_W] = '1;
    return m;
  endfunction
endpackage

// File: rtl/valreg_perm.sv
module valreg_perm (
  input  logic is_write,
  input  logic is_secure,
  input  logic is_priv,
  input  logic lowpriv_allow,
  input  logic sec_wr_lock,
  output logic fault
);
  logic low_priv_blocked;
  logic sec_write_blocked;

  always_comb begin
    low_priv_blocked  = !lowpriv_allow && (!is_secure || !is_priv);
    sec_write_blocked = is_secure && is_priv && is_write && sec_wr_lock;
    fault             = low_priv_blocked || sec_write_blocked;
  end
endmodule

// File: rtl/valreg_code_check.sv
module valreg_code_check
  import valreg_pkg::*;
#(
  parameter int unsigned NF = N_FIELDS,
  parameter int unsigned NC = N_CACHE
) (
  input  logic [NF-1:0][CODE_W-1:0] codes,
  output logic                      all_ok
);
  logic [NF-1:0] field_ok;

  for (genvar i = 0; i < int'(NF); i++) begin : g_field
    if (i < int'(NC)) begin : g_cache
      assign field_ok[i] = cache_code_ok(codes[i]);
    end else begin : g_tcm
      assign field_ok[i] = tcm_code_ok(codes[i]);
    end
  end

  assign all_ok = &field_ok;
endmodule

// File: rtl/valreg_size_reg.sv
module valreg_size_reg
  import valreg_pkg::*;
#(
  parameter int unsigned NF = N_FIELDS,
  parameter logic [NF*CODE_W-1:0] RST_VAL = '0
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      load,
  input  logic [NF-1:0][CODE_W-1:0] d,
  output logic [NF-1:0][CODE_W-1:0] q
);
  logic [NF-1:0][CODE_W-1:0] q_r;
  logic [NF-1:0][CODE_W-1:0] q_nxt;

  always_comb begin
    q_nxt = q_r;
    if (load) q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= RST_VAL;
    else        q_r <= q_nxt;
  end

  assign q = q_r;
endmodule

// File: rtl/valreg_access.sv
module valreg_access
  import valreg_pkg::*;
#(
  parameter logic [N_FIELDS*CODE_W-1:0] RST_SIZES = 12'b101_100_110_111
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic              acc_secure,
  input  logic              acc_priv,
  input  logic              acc_sel,
  input  logic [DATA_W-1:0] acc_wdata,
  input  logic              lowpriv_allow,
  input  logic              sec_wr_lock,
  output logic              resp_valid,
  output logic              undef_exc,
  output logic [DATA_W-1:0] resp_rdata,
  output logic [CODE_W-1:0] dtcm_size,
  output logic [CODE_W-1:0] itcm_size,
  output logic [CODE_W-1:0] dcache_size,
  output logic [CODE_W-1:0] icache_size
);
  localparam logic [DATA_W-1:0] USED_MASK = used_bits();

  logic      fault;
  logic      codes_ok;
  logic      size_load;
  logic      hit_size;
  size_vec_t cand;
  size_vec_t cur;
  logic [DATA_W-1:0] rd_image;
  logic      unused_wdata;

  logic              rv_q, rv_d;
  logic              ux_q, ux_d;
  logic [DATA_W-1:0] rd_q, rd_d;

  assign unused_wdata = ^(acc_wdata & ~USED_MASK);

  for (genvar i = 0; i < int'(N_FIELDS); i++) begin : g_slice
    assign cand[i] = acc_wdata[i*FIELD_STRIDE +: CODE_W];
  end

  always_comb begin
    rd_image = '0;
    for (int i = 0; i < int'(N_FIELDS); i++)
      rd_image[i*FIELD_STRIDE +: CODE_W] = cur[i];
  end

  valreg_perm u_perm (
    .is_write      (acc_write),
    .is_secure     (acc_secure),
    .is_priv       (acc_priv),
    .lowpriv_allow (lowpriv_allow),
    .sec_wr_lock   (sec_wr_lock),
    .fault         (fault)
  );

  valreg_code_check #(.NF(N_FIELDS), .NC(N_CACHE)) u_codes (
    .codes  (cand),
    .all_ok (codes_ok)
  );

  assign hit_size  = acc_valid && !fault && (reg_sel_e'(acc_sel) == SEL_SIZE);
  assign size_load = hit_size && acc_write && acc_wdata[WEN_BIT] && codes_ok;

  valreg_size_reg #(.NF(N_FIELDS), .RST_VAL(RST_SIZES)) u_sizes (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (size_load),
    .d     (cand),
    .q     (cur)
  );

  always_comb begin
    rv_d = acc_valid;
    ux_d = acc_valid && fault;
    rd_d = '0;
    if (hit_size && !acc_write) rd_d = rd_image;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rv_q <= 1'b0;
      ux_q <= 1'b0;
      rd_q <= '0;
    end else begin
      rv_q <= rv_d;
      ux_q <= ux_d;
      rd_q <= rd_d;
    end
  end

  assign resp_valid  = rv_q;
  assign undef_exc   = ux_q;
  assign resp_rdata  = rd_q;
  assign icache_size = cur[0];
  assign dcache_size = cur[1];
  assign itcm_size   = cur[2];
  assign dtcm_size   = cur[3];
endmodule

// File: rtl/valreg_access_sva.sv
module valreg_access_sva
  import valreg_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              acc_valid,
  input logic              acc_write,
  input logic              acc_secure,
  input logic              acc_priv,
  input logic              acc_sel,
  input logic [DATA_W-1:0] acc_wdata,
  input logic              lowpriv_allow,
  input logic              sec_wr_lock,
  input logic              resp_valid,
  input logic              undef_exc,
  input logic [DATA_W-1:0] resp_rdata,
  input logic [CODE_W-1:0] dtcm_size,
  input logic [CODE_W-1:0] itcm_size,
  input logic [CODE_W-1:0] dcache_size,
  input logic [CODE_W-1:0] icache_size
);
  logic size_wr_en;
  logic sizes_legal;
  assign size_wr_en  = acc_valid && acc_write && (acc_sel == 1'b0) && acc_wdata[WEN_BIT];
  assign sizes_legal = tcm_code_ok(dtcm_size) && tcm_code_ok(itcm_size) &&
                       cache_code_ok(dcache_size) && cache_code_ok(icache_size);

  p_resp_follows_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> resp_valid);
  p_quiet_when_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !resp_valid |-> (!undef_exc && resp_rdata == '0));
  p_lowpriv_blocked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !lowpriv_allow && (!acc_secure || !acc_priv)) |=> undef_exc);
  p_sec_write_lock_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write && acc_secure && acc_priv && sec_wr_lock) |=> undef_exc);
  p_no_wen_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !size_wr_en |=> ($stable(dtcm_size) && $stable(itcm_size) &&
                     $stable(dcache_size) && $stable(icache_size)));
  p_fault_no_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
    undef_exc |-> resp_rdata == '0);
  p_sbz_read_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> (resp_rdata[31:15] == '0 && resp_rdata[11] == 1'b0 &&
                    resp_rdata[7] == 1'b0 && resp_rdata[3] == 1'b0));
  p_codes_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sizes_legal);
endmodule

bind valreg_access valreg_access_sva u_sva (
  .clk           (clk),
  .rst_n         (rst_n),
  .acc_valid     (acc_valid),
  .acc_write     (acc_write),
  .acc_secure    (acc_secure),
  .acc_priv      (acc_priv),
  .acc_sel       (acc_sel),
  .acc_wdata     (acc_wdata),
  .lowpriv_allow (lowpriv_allow),
  .sec_wr_lock   (sec_wr_lock),
  .resp_valid    (resp_valid),
  .undef_exc     (undef_exc),
  .resp_rdata    (resp_rdata),
  .dtcm_size     (dtcm_size),
  .itcm_size     (itcm_size),
  .dcache_size   (dcache_size),
  .icache_size   (icache_size)
);

// File: tb/valreg_access_test.sv
module valreg_access_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [11:0] RST_SZ = 12'b101_100_110_111;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        acc_valid, acc_write, acc_secure, acc_priv, acc_sel;
  logic [31:0] acc_wdata;
  logic        lowpriv_allow, sec_wr_lock;
  logic        resp_valid, undef_exc;
  logic [31:0] resp_rdata;
  logic [2:0]  dtcm_size, itcm_size, dcache_size, icache_size;

  int errors = 0;
  int checks = 0;
  logic [11:0] model;  // {dtcm, itcm, dcache, icache}

  always #(CLK_PERIOD/2) clk = ~clk;

  valreg_access uut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_secure(acc_secure), .acc_priv(acc_priv), .acc_sel(acc_sel),
    .acc_wdata(acc_wdata), .lowpriv_allow(lowpriv_allow), .sec_wr_lock(sec_wr_lock),
    .resp_valid(resp_valid), .undef_exc(undef_exc), .resp_rdata(resp_rdata),
    .dtcm_size(dtcm_size), .itcm_size(itcm_size), .dcache_size(dcache_size),
    .icache_size(icache_size)
  );

  function automatic logic exp_fault(input logic w, s, p, v, lk);
    return (!v && (!s || !p)) || (s && p && w && lk);
  endfunction

  function automatic logic exp_legal(input logic [31:0] d);
    logic ok;
    ok = (d[2:0] >= 3'd3) && (d[6:4] >= 3'd3);
    ok = ok && (d[10:8] == 3'd0 || d[10:8] >= 3'd3);
    ok = ok && (d[14:12] == 3'd0 || d[14:12] >= 3'd3);
    return ok;
  endfunction

  function automatic logic [31:0] exp_image(input logic [11:0] m);
    return {17'd0, m[11:9], 1'b0, m[8:6], 1'b0, m[5:3], 1'b0, m[2:0]};
  endfunction

  task automatic chk(input string tag, input logic ok, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_req(input logic vld, w, s, p, sel, input logic [31:0] d,
                        input logic v, lk);
    logic f;
    logic [31:0] erd;
    logic [11:0] act_sz;
    string ftag, rtag, stag;
    acc_valid = vld; acc_write = w; acc_secure = s; acc_priv = p; acc_sel = sel;
    acc_wdata = d; lowpriv_allow = v; sec_wr_lock = lk;
    f   = vld && exp_fault(w, s, p, v, lk);
    erd = (vld && !f && !w && !sel) ? exp_image(model) : 32'd0;
    if (vld && !f && w && !sel && d[31] && exp_legal(d))
      model = {d[14:12], d[10:8], d[6:4], d[2:0]};
    ftag = !v ? "R2" : ((s && p && w && lk) ? "R4" : "R3");
    rtag = f ? "R9" : (sel ? "R10" : "R7");
    stag = f ? "R9" : (sel ? "R10" : (!w ? "R7" : (!d[31] ? "R6" : (exp_legal(d) ? "R5" : "R8"))));
    @(posedge clk);
    @(negedge clk);
    act_sz = {dtcm_size, itcm_size, dcache_size, icache_size};
    chk("R11", resp_valid == vld, {31'd0, resp_valid}, {31'd0, vld});
    if (vld) chk(ftag, undef_exc == f, {31'd0, undef_exc}, {31'd0, f});
    chk(rtag, resp_rdata == erd, resp_rdata, erd);
    chk(stag, act_sz == model, {20'd0, act_sz}, {20'd0, model});
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    acc_valid = 0; acc_write = 0; acc_secure = 0; acc_priv = 0; acc_sel = 0;
    acc_wdata = '0; lowpriv_allow = 0; sec_wr_lock = 0;
    model = RST_SZ;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", resp_valid == 1'b0 && undef_exc == 1'b0, {30'd0, resp_valid, undef_exc}, 32'd0);
    chk("R1", resp_rdata == 32'd0, resp_rdata, 32'd0);
    chk("R1", {dtcm_size, itcm_size, dcache_size, icache_size} == RST_SZ,
        {20'd0, dtcm_size, itcm_size, dcache_size, icache_size}, {20'd0, RST_SZ});
    rst_n = 1'b1;
    @(negedge clk);

    // directed corners
    do_req(1, 0, 1, 1, 0, 32'h0, 0, 0);                 // R7 secure priv read, V=0
    do_req(1, 0, 0, 1, 0, 32'h0, 0, 0);                 // R2 non-secure read blocked
    do_req(1, 1, 1, 0, 0, 32'h8000_3777, 0, 0);         // R2 secure user write blocked
    do_req(1, 1, 0, 1, 0, 32'h8000_3443, 1, 0);         // R3/R5 non-secure write loads
    do_req(1, 0, 0, 0, 0, 32'h0, 1, 1);                 // R3 user read, lock irrelevant
    do_req(1, 1, 1, 1, 0, 32'h8000_7777, 1, 1);         // R4 locked secure write
    do_req(1, 0, 1, 1, 0, 32'h0, 1, 1);                 // R4 locked secure read ok
    do_req(1, 1, 1, 1, 0, 32'h0000_0333, 1, 0);         // R6 no write enable
    do_req(1, 1, 1, 1, 0, 32'h8000_0344, 1, 0);         // R8 TCM code 000 legal
    do_req(1, 1, 1, 1, 0, 32'h8000_7707, 1, 0);         // R8 cache code 000 reserved
    do_req(1, 1, 1, 1, 0, 32'h8000_1777, 1, 0);         // R8 TCM code 001 reserved
    do_req(1, 1, 1, 1, 0, 32'hFFFF_F777, 1, 0);         // R5/R7 SBZ bits set on write
    do_req(1, 0, 1, 1, 0, 32'h0, 1, 0);                 // R7 read SBZ zero
    do_req(1, 0, 1, 1, 1, 32'h0, 1, 0);                 // R10 ops read zero
    do_req(1, 1, 1, 1, 1, 32'h8000_3333, 1, 0);         // R10 ops write no effect
    do_req(0, 1, 1, 1, 0, 32'h8000_3333, 1, 0);         // R11 idle, no update
    do_req(1, 0, 0, 0, 0, 32'h0, 0, 1);                 // R9 faulting read data zero

    for (int n = 0; n < 3000; n++) begin
      logic [31:0] d;
      d = $urandom;
      do_req(($urandom % 5) != 0, $urandom % 2, $urandom % 2, $urandom % 2,
             ($urandom % 4) == 0, d, ($urandom % 4) != 0, ($urandom % 4) == 0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule